// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Unit

This block gathers the normal interrupt events of an SD host controller into one 16-bit status word and drives a single interrupt line. The command and data engines supply single-cycle event pulses. The buffer logic supplies two readiness levels, and the block watches those levels for rising edges. The raw active-low card-detect pin is synchronized, inverted and debounced to produce present-state bits for the detect level, for card inserted and for card stable. Changes in the debounced presence set the insertion and removal events. The DAT[1] line is synchronized and shown as the card interrupt bit.

Latched status bits are cleared by writing 1 to their position. An event can only latch if its status-enable bit is 1. The interrupt line is the OR of every status bit gated by its signal-enable bit. Two small state machines carry the sequencing:

- **Debouncer.** It has the states `DB_WAIT` and `DB_SETTLED`. The transition *restart* happens on any level change and re-enters `DB_WAIT`. The transition *settle* happens when the counter expires and moves from `DB_WAIT` to `DB_SETTLED`.
- **Transfer tracker.** It has the states `XF_ARMED` and `XF_DONE`. The transition *finish* is taken on transfer complete. The transition *rearm* is taken on a new transfer start. While the tracker is in `XF_DONE`, DMA boundary events are dropped.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After reset, every latched status bit is 0. `irq_o`, `card_inserted_o` and `card_stable_o` are 0, and `cd_level_o` is 0.
- R2: Bit 0 (command complete) latches on `resp_end_i` unless, in the same cycle, `resp_auto_i` marks an automatic stop or block-count command, or `resp_irq_off_i` is 1.
- R3: Bit 1 (transfer complete), bit 2 (block gap) and bit 13 (response check event) latch on a pulse of `xfer_done_i`, `blk_gap_i` and `fx_hit_i` respectively.
- R4: Bit 3 (DMA) latches on `dma_bnd_i` only while the tracker is armed and `xfer_done_i` is 0. Once `xfer_done_i` has pulsed, DMA events are dropped until `xfer_start_i` pulses.
- R5: Bit 4 latches on a 0-to-1 transition of `buf_wr_lvl_i`, and bit 5 latches on a 0-to-1 transition of `buf_rd_lvl_i`. A level that stays high sets nothing further.
- R6: When `clr_we_i` is 1, each latched bit whose `clr_data_i` bit is 1 clears. If a set event for that bit occurs in the same cycle, the bit stays set.
- R7: An event whose `stat_en_i` bit is 0 never latches. Bits 9 to 12 and bit 14 always read 0.
- R8: `cd_level_o` is the inverse of `card_det_n_i` after two flops. `card_inserted_o` takes the level only after the level has been unchanged for `DB_CYCLES` consecutive cycles, counted from the cycle after the change. `card_stable_o` is 0 in the same cycle that the level differs from its last value, and is 1 only when the level is settled.
- R9: Bit 6 latches when `card_inserted_o` rises, and bit 7 latches when it falls.
- R10: Bit 8 equals the two-flop synchronized `dat1_i` ANDed with `stat_en_i[8]`. It is not latched.
- R11: Bit 15 reads 1 whenever any bit of `err_status_i` is 1, in the same cycle. A clear write has no effect on it.
- R12: `irq_o` is 1 exactly when some bit of `int_status_o` is 1 together with the same bit of `sig_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_end_i | input | 1 | Response end-bit pulse |
| resp_auto_i | input | 1 | Qualifies the response as belonging to an automatically issued stop or block-count command |
| resp_irq_off_i | input | 1 | Response interrupt disabled |
| xfer_done_i | input | 1 | Transfer complete pulse |
| xfer_start_i | input | 1 | New transfer start pulse; re-arms DMA events |
| blk_gap_i | input | 1 | Stop-at-block-gap reached pulse |
| dma_bnd_i | input | 1 | DMA boundary or descriptor interrupt pulse |
| fx_hit_i | input | 1 | Response check event pulse |
| buf_wr_lvl_i | input | 1 | Buffer has room for write data (level) |
| buf_rd_lvl_i | input | 1 | Buffer holds read data (level) |
| card_det_n_i | input | 1 | Raw active-low card-detect pin |
| dat1_i | input | 1 | Raw DAT[1] line |
| err_status_i | input | 16 | Error interrupt status word |
| stat_en_i | input | 16 | Status-enable mask |
| sig_en_i | input | 16 | Signal-enable mask for the interrupt line |
| clr_we_i | input | 1 | Clear-write strobe |
| clr_data_i | input | 16 | Write-1-to-clear data |
| int_status_o | output | 16 | Normal interrupt status word |
| irq_o | output | 1 | Interrupt request |
| cd_level_o | output | 1 | Synchronized card-detect level, active high |
| card_inserted_o | output | 1 | Debounced card presence |
| card_stable_o | output | 1 | Detect level has settled |

## Verification
The event pulses and the buffer edges show up in `int_status_o` one rising edge after the cycle in which they are driven. `cd_level_o` and bit 8 take two edges. Bit 15 and `irq_o` respond in the same cycle. Bits 6 and 7 follow `card_inserted_o` by one edge, and `card_inserted_o` follows a level change by `DB_CYCLES`+1 edges. The bench drives inputs on the falling edge and samples on a later falling edge after exactly the counted rising edges. The randomized phase runs a cycle model that predicts the status word for the next falling edge from the inputs applied in the current one.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
    localparam int STW = 16;
    typedef logic [STW-1:0] stat_vec_t;

    localparam int B_CMD  = 0;
    localparam int B_XFER = 1;
    localparam int B_GAP  = 2;
    localparam int B_DMA  = 3;
    localparam int B_WRDY = 4;
    localparam int B_RRDY = 5;
    localparam int B_INS  = 6;
    localparam int B_REM  = 7;
    localparam int B_CINT = 8;
    localparam int B_FX   = 13;
    localparam int B_ERR  = 15;

    // bits that hold their value until cleared
    localparam stat_vec_t LATCH_MASK = stat_vec_t'(16'h20FF);

    typedef enum logic [0:0] {DB_WAIT, DB_SETTLED} db_state_e;
    typedef enum logic [0:0] {XF_ARMED, XF_DONE} xf_state_e;
endpackage

// File: rtl/sdirq_sync.sv
module sdirq_sync #(
    parameter int       W       = 1,
    parameter int       STAGES  = 2,
    parameter logic     RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_VAL}};
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdirq_debounce.sv
module sdirq_debounce
    import sdirq_pkg::*;
#(
    parameter int DB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic inserted_o,
    output logic stable_o
);
    localparam int CW = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DB_CYCLES - 1);

    db_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          prev_q, prev_d;
    logic          ins_q, ins_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_WAIT;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
            ins_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= prev_d;
            ins_q   <= ins_d;
        end
    end

    // next state: restart on any change, settle when the counter expires
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prev_d  = prev_q;
        ins_d   = ins_q;
        unique case (state_q)
            DB_WAIT: begin
                if (level_i != prev_q) begin
                    prev_d = level_i;
                    cnt_d  = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_SETTLED;
                    ins_d   = prev_q;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            DB_SETTLED: begin
                if (level_i != prev_q) begin
                    state_d = DB_WAIT;
                    prev_d  = level_i;
                    cnt_d   = '0;
                end
            end
            default: state_d = DB_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        inserted_o = ins_q;
        stable_o   = (state_q == DB_SETTLED) && (level_i == prev_q);
    end

    assert_hold_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_q != $past(ins_q)) |-> ($past(cnt_q) == CNT_LAST));

    assert_stable_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stable_o |-> (inserted_o == level_i));
endmodule

// File: rtl/sdirq_xfer_track.sv
module sdirq_xfer_track
    import sdirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_done_i,
    input  logic xfer_start_i,
    output logic dma_allow_o
);
    xf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_ARMED;
        else        state_q <= state_d;
    end

    // finish on completion (wins over a same-cycle start), rearm on start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_ARMED: if (xfer_done_i) state_d = XF_DONE;
            XF_DONE:  if (xfer_start_i && !xfer_done_i) state_d = XF_ARMED;
            default:  state_d = XF_ARMED;
        endcase
    end

    always_comb begin
        dma_allow_o = (state_q == XF_ARMED) && !xfer_done_i;
    end

    assert_dma_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer_done_i) && !xfer_start_i) |-> !dma_allow_o);
endmodule

// File: rtl/sdirq_status_bank.sv
module sdirq_status_bank
    import sdirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      resp_end_i,
    input  logic      resp_auto_i,
    input  logic      resp_irq_off_i,
    input  logic      xfer_done_i,
    input  logic      blk_gap_i,
    input  logic      dma_bnd_i,
    input  logic      dma_allow_i,
    input  logic      fx_hit_i,
    input  logic      buf_wr_lvl_i,
    input  logic      buf_rd_lvl_i,
    input  logic      inserted_i,
    input  logic      card_int_i,
    input  logic      err_any_i,
    input  stat_vec_t stat_en_i,
    input  logic      clr_we_i,
    input  stat_vec_t clr_data_i,
    output stat_vec_t status_o
);
    stat_vec_t raw_set, set_vec, clr_vec, lat_q, lat_d;
    logic      wr_prev_q, rd_prev_q, ins_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q      <= '0;
            wr_prev_q  <= 1'b0;
            rd_prev_q  <= 1'b0;
            ins_prev_q <= 1'b0;
        end else begin
            lat_q      <= lat_d;
            wr_prev_q  <= buf_wr_lvl_i;
            rd_prev_q  <= buf_rd_lvl_i;
            ins_prev_q <= inserted_i;
        end
    end

    always_comb begin
        raw_set         = '0;
        raw_set[B_CMD]  = resp_end_i && !resp_auto_i && !resp_irq_off_i;
        raw_set[B_XFER] = xfer_done_i;
        raw_set[B_GAP]  = blk_gap_i;
        raw_set[B_DMA]  = dma_bnd_i && dma_allow_i;
        raw_set[B_WRDY] = buf_wr_lvl_i && !wr_prev_q;
        raw_set[B_RRDY] = buf_rd_lvl_i && !rd_prev_q;
        raw_set[B_INS]  = inserted_i && !ins_prev_q;
        raw_set[B_REM]  = !inserted_i && ins_prev_q;
        raw_set[B_FX]   = fx_hit_i;
        set_vec = raw_set & stat_en_i & LATCH_MASK;
        clr_vec = clr_we_i ? clr_data_i : '0;
        lat_d   = ((lat_q & ~clr_vec) | set_vec) & LATCH_MASK;
    end

    always_comb begin
        status_o         = lat_q;
        status_o[B_CINT] = card_int_i && stat_en_i[B_CINT];
        status_o[B_ERR]  = err_any_i;
    end

    assert_auto_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_end_i && resp_auto_i && !lat_q[B_CMD]) |=> !lat_q[B_CMD]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_data_i[B_GAP] && !blk_gap_i) |=> !lat_q[B_GAP]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && stat_en_i[B_XFER]) |=> lat_q[B_XFER]);

    assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_en_i[B_FX] && !lat_q[B_FX]) |=> !lat_q[B_FX]);

    assert_dma_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_allow_i && !lat_q[B_DMA]) |=> !lat_q[B_DMA]);
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
    import sdirq_pkg::*;
#(
    parameter int DB_CYCLES   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        resp_end_i,
    input  logic        resp_auto_i,
    input  logic        resp_irq_off_i,
    input  logic        xfer_done_i,
    input  logic        xfer_start_i,
    input  logic        blk_gap_i,
    input  logic        dma_bnd_i,
    input  logic        fx_hit_i,
    input  logic        buf_wr_lvl_i,
    input  logic        buf_rd_lvl_i,
    input  logic        card_det_n_i,
    input  logic        dat1_i,
    input  logic [15:0] err_status_i,
    input  logic [15:0] stat_en_i,
    input  logic [15:0] sig_en_i,
    input  logic        clr_we_i,
    input  logic [15:0] clr_data_i,
    output logic [15:0] int_status_o,
    output logic        irq_o,
    output logic        cd_level_o,
    output logic        card_inserted_o,
    output logic        card_stable_o
);
    logic cd_n_sync, dat1_sync, dma_allow;
    stat_vec_t status;

    sdirq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cd_sync (
        .clk(clk), .rst_n(rst_n), .d_i(card_det_n_i), .q_o(cd_n_sync));

    sdirq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dat1_sync (
        .clk(clk), .rst_n(rst_n), .d_i(dat1_i), .q_o(dat1_sync));

    assign cd_level_o = !cd_n_sync;

    sdirq_debounce #(.DB_CYCLES(DB_CYCLES)) u_debounce (
        .clk(clk), .rst_n(rst_n), .level_i(cd_level_o),
        .inserted_o(card_inserted_o), .stable_o(card_stable_o));

    sdirq_xfer_track u_xfer (
        .clk(clk), .rst_n(rst_n), .xfer_done_i(xfer_done_i),
        .xfer_start_i(xfer_start_i), .dma_allow_o(dma_allow));

    sdirq_status_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .resp_end_i(resp_end_i), .resp_auto_i(resp_auto_i),
        .resp_irq_off_i(resp_irq_off_i), .xfer_done_i(xfer_done_i),
        .blk_gap_i(blk_gap_i), .dma_bnd_i(dma_bnd_i), .dma_allow_i(dma_allow),
        .fx_hit_i(fx_hit_i), .buf_wr_lvl_i(buf_wr_lvl_i),
        .buf_rd_lvl_i(buf_rd_lvl_i), .inserted_i(card_inserted_o),
        .card_int_i(dat1_sync), .err_any_i(|err_status_i),
        .stat_en_i(stat_en_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
        .status_o(status));

    assign int_status_o = status;
    assign irq_o        = |(status & sig_en_i);

    assert_card_int_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_status_o[B_CINT] |-> stat_en_i[B_CINT]);

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|int_status_o));
endmodule

// File: tb/sd_irq_status_unit_test.sv
`timescale 1ns/1ps
module sd_irq_status_unit_test;
    localparam int DB = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic resp_end = 0, resp_auto = 0, resp_off = 0, xdone = 0, xstart = 0;
    logic gap = 0, dma = 0, fx = 0, wrl = 0, rdl = 0, cdn = 1'b1, dat1 = 0;
    logic [15:0] err = '0, sen = '0, gen = '0, cdata = '0;
    logic cwe = 0;
    logic [15:0] st;
    logic irq, cdl, ins, stb;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    sd_irq_status_unit #(.DB_CYCLES(DB)) uut (
        .clk(clk), .rst_n(rst_n), .resp_end_i(resp_end), .resp_auto_i(resp_auto),
        .resp_irq_off_i(resp_off), .xfer_done_i(xdone), .xfer_start_i(xstart),
        .blk_gap_i(gap), .dma_bnd_i(dma), .fx_hit_i(fx), .buf_wr_lvl_i(wrl),
        .buf_rd_lvl_i(rdl), .card_det_n_i(cdn), .dat1_i(dat1),
        .err_status_i(err), .stat_en_i(sen), .sig_en_i(gen), .clr_we_i(cwe),
        .clr_data_i(cdata), .int_status_o(st), .irq_o(irq), .cd_level_o(cdl),
        .card_inserted_o(ins), .card_stable_o(stb));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        resp_end = 0; resp_auto = 0; resp_off = 0; xdone = 0; xstart = 0;
        gap = 0; dma = 0; fx = 0; cwe = 0; cdata = '0;
    endtask

    task automatic clear_all();
        cwe = 1; cdata = 16'hFFFF; tick(1); idle(); tick(1);
    endtask

    function automatic logic [15:0] model_set(
        input logic re, ra, ro, xd, gp, dm, fh, wl, rl, pw, pr, armed,
        input logic [15:0] en);
        logic [15:0] s = '0;
        s[0]  = re && !ra && !ro;
        s[1]  = xd;
        s[2]  = gp;
        s[3]  = dm && armed && !xd;
        s[4]  = wl && !pw;
        s[5]  = rl && !pr;
        s[13] = fh;
        return s & en;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 status", st, 16'h0);
        chk("R1 irq", irq, 0);
        chk("R1 inserted", ins, 0);
        chk("R1 stable", stb, 0);
        chk("R1 level", cdl, 0);

        sen = 16'hFFFF; gen = '0;
        tick(DB + 6);
        chk("R8 stable after settle", stb, 1);

        // R8 insertion: level after two edges
        cdn = 1'b0;
        tick(1);
        chk("R8 level one edge", cdl, 0);
        tick(1);
        chk("R8 level two edges", cdl, 1);
        chk("R8 stable drops", stb, 0);
        tick(DB - 2);
        chk("R8 inserted held early", ins, 0);
        tick(12);
        chk("R8 inserted", ins, 1);
        chk("R8 stable", stb, 1);
        chk("R9 insertion bit", st[6], 1);
        chk("R9 no removal", st[7], 0);

        // R8 glitch shorter than window
        cdn = 1'b1; tick(2);
        chk("R8 glitch level", cdl, 0);
        chk("R8 glitch stable", stb, 0);
        tick(4); cdn = 1'b0;
        tick(DB + 10);
        chk("R8 glitch ignored", ins, 1);
        chk("R9 glitch no removal", st[7], 0);

        // R9 removal
        cdn = 1'b1; tick(DB + 10);
        chk("R9 removed", ins, 0);
        chk("R9 removal bit", st[7], 1);
        clear_all();
        chk("R6 cleared", st, 16'h0);

        // R10 card interrupt
        dat1 = 1; tick(1);
        chk("R10 one edge", st[8], 0);
        tick(1);
        chk("R10 follows", st[8], 1);
        sen[8] = 0; #1;
        chk("R10 masked", st[8], 0);
        sen[8] = 1; dat1 = 0; tick(2);
        chk("R10 not latched", st[8], 0);

        // R11 error summary, R12 irq
        err = 16'h0004; #1;
        chk("R11 summary", st[15], 1);
        gen = 16'h8000; #1;
        chk("R12 irq on", irq, 1);
        gen = 16'h7FFF; #1;
        chk("R12 irq gated", irq, 0);
        cwe = 1; cdata = 16'h8000; tick(1); idle(); tick(1);
        chk("R11 not clearable", st[15], 1);
        err = '0; #1;
        chk("R11 follows", st[15], 0);
        gen = '0;

        // R2 command complete
        resp_end = 1; resp_auto = 1; tick(1); idle(); tick(1);
        chk("R2 auto suppressed", st[0], 0);
        resp_end = 1; resp_off = 1; tick(1); idle(); tick(1);
        chk("R2 irq off suppressed", st[0], 0);
        resp_end = 1; tick(1); idle();
        chk("R2 one edge", st[0], 1);
        // R6 set wins
        resp_end = 1; cwe = 1; cdata = 16'h0001; tick(1); idle();
        chk("R6 set wins", st[0], 1);
        cwe = 1; cdata = 16'h0001; tick(1); idle();
        chk("R6 clear", st[0], 0);

        // R3 / R4
        xdone = 1; tick(1); idle();
        chk("R3 xfer done", st[1], 1);
        dma = 1; tick(1); idle(); tick(1);
        chk("R4 dma blocked", st[3], 0);
        xstart = 1; tick(1); idle();
        dma = 1; tick(1); idle();
        chk("R4 dma rearmed", st[3], 1);
        fx = 1; tick(1); idle();
        chk("R3 fx", st[13], 1);

        // R7 mask
        sen[2] = 0; gap = 1; tick(1); idle(); tick(1);
        chk("R7 masked gap", st[2], 0);
        sen = 16'hFFFF;

        // R5 directed
        clear_all();
        wrl = 1; tick(1);
        chk("R5 write edge", st[4], 1);
        cwe = 1; cdata = 16'h0010; tick(1); idle(); tick(1);
        chk("R5 held level no reset", st[4], 0);
        wrl = 0; tick(1);

        // randomized phase
        begin
            logic [15:0] exp = '0;
            logic armed = 1, pw = 0, pr = 0;
            xstart = 1; cwe = 1; cdata = 16'hFFFF; tick(1); idle(); wrl = 0; rdl = 0;
            tick(1);
            for (int i = 0; i < 3000; i++) begin
                logic [15:0] s, c;
                chk("R12 random irq", irq, |(exp & gen));
                chk("R3 R4 R5 R6 R7 random status", st, exp);
                resp_end = ($urandom % 3) == 0;
                resp_auto = ($urandom % 3) == 0;
                resp_off = ($urandom % 4) == 0;
                xdone = ($urandom % 6) == 0;
                xstart = ($urandom % 5) == 0;
                gap = ($urandom % 4) == 0;
                dma = ($urandom % 3) == 0;
                fx = ($urandom % 4) == 0;
                wrl = ($urandom % 2) == 0;
                rdl = ($urandom % 2) == 0;
                sen = 16'($urandom);
                gen = 16'($urandom);
                cwe = ($urandom % 3) == 0;
                cdata = 16'($urandom);
                s = model_set(resp_end, resp_auto, resp_off, xdone, gap, dma, fx,
                              wrl, rdl, pw, pr, armed, sen);
                c = cwe ? cdata : 16'h0;
                exp = ((exp & ~c) | s) & 16'h20FF;
                armed = xdone ? 1'b0 : (xstart ? 1'b1 : armed);
                pw = wrl; pr = rdl;
                tick(1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule